// File: doc/BRIEF.md
# Nested Stack Frame Builder

This block is a multi-cycle sequencer that builds the stack frame a procedure of a block-structured language needs on entry. A start strobe arrives with an allocation size, a nesting level, an operand-size code and the caller's stack and frame pointers. The block first pushes the old frame pointer and remembers the stack pointer it leaves behind. For nested procedures it then copies the older frame pointers of the enclosing scopes into a display area: it reads each one from the previous frame and pushes it. After that it pushes the remembered pointer. Last, it lowers the stack pointer by the allocation size and returns the new frame and stack pointers together with a one-cycle done pulse.

All traffic goes through one memory port with a request/ready handshake and never more than one access in flight. The final stack pointer is checked against a lower-bound input before any access is made. When the frame would fall below that bound, the block raises a one-cycle fault pulse and touches no memory.

Top module: `frame_builder`

## Requirements
- R1: Only the low 5 bits of `nest_lvl` count, so the effective level is `nest_lvl` mod 32 (33 acts as 1, 255 acts as 31).
- R2: Operand-size code `opsize` 2'b00 means 2 bytes, 2'b01 means 4 bytes, and 2'b10 or 2'b11 means 8 bytes. The first access is a write of the frame pointer to (stack pointer − size). Every push lowers the stack pointer by the size before it writes. Write data is the value truncated to the size, with the upper bits zero, and `mem_size` carries the code.
- R3: At level 0 the frame pointer push is the only access.
- R4: At level L ≥ 2 there are L−1 read/push pairs. Pass k reads address (frame pointer − k·size) and pushes the value read, truncated to the size.
- R5: At any level ≥ 1 the last access pushes the stack pointer value that was left after the first push.
- R6: On completion `fp_out` equals that saved value and `sp_out` equals the final stack pointer minus the zero-extended `alloc_size`. `done` is high for exactly one cycle.
- R7: With the 2-byte size, all pointer arithmetic, including access addresses, wraps within the low 16 bits. The upper bits of the stack pointer are kept, and `fp_out` keeps the upper bits of `fp_in`.
- R8: If the final stack pointer would be below `stack_floor` (unsigned), `fault` pulses for one cycle instead of `done`, no memory access is made, and `sp_out`/`fp_out` equal `sp_in`/`fp_in`. A final value equal to the floor is legal.
- R9: While `mem_req` is high and `mem_ready` is low, address, write enable and write data stay stable, and only one access is in flight.
- R10: `start` is ignored while `busy` is high.
- R11: Synchronous active-high `rst` returns the block to idle with no request, and with `done`, `fault`, `sp_out` and `fp_out` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin building a frame |
| alloc_size | input | 16 | Bytes of local storage to allocate |
| nest_lvl | input | 8 | Lexical nesting level (mod 32) |
| opsize | input | 2 | Operand-size code |
| sp_in | input | 64 | Current stack pointer |
| fp_in | input | 64 | Current frame pointer |
| stack_floor | input | 64 | Lowest legal final stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Operand-size code of the access |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data, low bytes valid |
| mem_rdata | input | 64 | Read data |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Frame build in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle stack-limit fault pulse |
| sp_out | output | 64 | Committed stack pointer |
| fp_out | output | 64 | Committed frame pointer |

## Verification
Completion of one frame and acceptance of the next start can fall in the same cycle. The bench always raises the next start on the very cycle it sees `done` or `fault`, and it judges the following frame by its full access trace and final pointers. A start that arrives while a build is in progress is the opposite case. The bench injects such a start, with unrelated operands, at the first handshake of some builds and checks that the trace and results of the current build are unchanged. Levels 0 to 33, 95 and 255 are swept across all four size codes, with pointers that wrap in the low 16 bits, and the bench places the fault boundary at the final stack pointer and one above it.

// File: rtl/frame_pkg.sv
package frame_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PUSH_FP,
        ST_RD_DISP,
        ST_PUSH_DISP,
        ST_PUSH_TMP,
        ST_FINISH
    } fb_state_e;

    // operand-size code to byte count; 2'b10 and 2'b11 both mean 8
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/frame_ptr_step.sv
// Subtracts an amount from a pointer; in narrow mode only the low bits wrap.
module frame_ptr_step #(
    parameter int W  = 64,
    parameter int NW = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] amount,
    input  logic         narrow,
    output logic [W-1:0] result
);
    logic [W-1:0]  wide_diff;
    logic [NW-1:0] low_diff;

    always_comb begin
        wide_diff = base - amount;
        low_diff  = base[NW-1:0] - amount[NW-1:0];
        result    = narrow ? {base[W-1:NW], low_diff} : wide_diff;
    end
endmodule

// File: rtl/frame_limit_chk.sv
// Predicts the final stack pointer of a frame and compares it with the floor.
module frame_limit_chk
    import frame_pkg::*;
#(
    parameter int W       = 64,
    parameter int NW      = 16,
    parameter int LVL_W   = 5,
    parameter int ALLOC_W = 16
) (
    input  logic [W-1:0]       sp_start,
    input  logic [W-1:0]       floor_v,
    input  logic [LVL_W-1:0]   level,
    input  logic [ALLOC_W-1:0] alloc,
    input  logic [1:0]         code,
    output logic [W-1:0]       final_sp,
    output logic               below
);
    logic [W-1:0] push_cnt;
    logic [W-1:0] total;

    always_comb begin
        push_cnt = (level == '0) ? W'(1) : W'(level) + W'(1);
        total    = push_cnt * W'(size_bytes(code)) + W'(alloc);
    end

    frame_ptr_step #(.W(W), .NW(NW)) u_final (
        .base   (sp_start),
        .amount (total),
        .narrow (code == 2'b00),
        .result (final_sp)
    );

    assign below = final_sp < floor_v;
endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import frame_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int ALLOC_W  = 16,
    parameter int LVL_W    = 8,
    parameter int NEST_W   = 5,
    parameter int NARROW_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ALLOC_W-1:0] alloc_size,
    input  logic [LVL_W-1:0]   nest_lvl,
    input  logic [1:0]         opsize,
    input  logic [PTR_W-1:0]   sp_in,
    input  logic [PTR_W-1:0]   fp_in,
    input  logic [PTR_W-1:0]   stack_floor,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_size,
    output logic [PTR_W-1:0]   mem_addr,
    output logic [PTR_W-1:0]   mem_wdata,
    input  logic [PTR_W-1:0]   mem_rdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [PTR_W-1:0]   sp_out,
    output logic [PTR_W-1:0]   fp_out
);
    localparam int MID_W = 32;

    typedef struct packed {
        fb_state_e          st;
        logic [PTR_W-1:0]   sp;
        logic [PTR_W-1:0]   fp;
        logic [PTR_W-1:0]   tmp;
        logic [PTR_W-1:0]   sp0;
        logic [PTR_W-1:0]   fp0;
        logic [PTR_W-1:0]   floor_v;
        logic [PTR_W-1:0]   addr;
        logic [PTR_W-1:0]   wdata;
        logic [PTR_W-1:0]   sp_res;
        logic [PTR_W-1:0]   fp_res;
        logic [ALLOC_W-1:0] alloc;
        logic [NEST_W-1:0]  lvl;
        logic [NEST_W-1:0]  cnt;
        logic [1:0]         code;
        logic               we;
        logic               done;
        logic               fault;
    } ctx_t;

    // keep only the bytes of the operand size, upper bits zero
    function automatic logic [PTR_W-1:0] fit(input logic [PTR_W-1:0] v,
                                             input logic [1:0] c);
        case (c)
            2'b00:   return {{(PTR_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
            2'b01:   return {{(PTR_W-MID_W){1'b0}}, v[MID_W-1:0]};
            default: return v;
        endcase
    endfunction

    ctx_t ctx_d, ctx_q;

    logic             narrow;
    logic [PTR_W-1:0] step_amt;
    logic [PTR_W-1:0] alloc_ext;
    logic [PTR_W-1:0] sp_dec;
    logic [PTR_W-1:0] fp_dec;
    logic [PTR_W-1:0] sp_fin;
    logic [PTR_W-1:0] pred_sp;
    logic             limit_hit;

    assign narrow    = (ctx_q.code == 2'b00);
    assign step_amt  = PTR_W'(size_bytes(ctx_q.code));
    assign alloc_ext = PTR_W'(ctx_q.alloc);

    frame_ptr_step #(.W(PTR_W), .NW(NARROW_W)) u_sp_step (
        .base(ctx_q.sp), .amount(step_amt), .narrow(narrow), .result(sp_dec)
    );

    frame_ptr_step #(.W(PTR_W), .NW(NARROW_W)) u_fp_step (
        .base(ctx_q.fp), .amount(step_amt), .narrow(narrow), .result(fp_dec)
    );

    frame_ptr_step #(.W(PTR_W), .NW(NARROW_W)) u_sp_alloc (
        .base(ctx_q.sp), .amount(alloc_ext), .narrow(narrow), .result(sp_fin)
    );

    frame_limit_chk #(
        .W(PTR_W), .NW(NARROW_W), .LVL_W(NEST_W), .ALLOC_W(ALLOC_W)
    ) u_limit (
        .sp_start (ctx_q.sp0),
        .floor_v  (ctx_q.floor_v),
        .level    (ctx_q.lvl),
        .alloc    (ctx_q.alloc),
        .code     (ctx_q.code),
        .final_sp (pred_sp),
        .below    (limit_hit)
    );

    always_comb begin
        ctx_d       = ctx_q;
        ctx_d.done  = 1'b0;
        ctx_d.fault = 1'b0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.sp      = sp_in;
                    ctx_d.fp      = fp_in;
                    ctx_d.sp0     = sp_in;
                    ctx_d.fp0     = fp_in;
                    ctx_d.floor_v = stack_floor;
                    ctx_d.alloc   = alloc_size;
                    ctx_d.lvl     = nest_lvl[NEST_W-1:0];
                    ctx_d.code    = opsize;
                    ctx_d.st      = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (limit_hit) begin
                    ctx_d.fault  = 1'b1;
                    ctx_d.sp_res = ctx_q.sp0;
                    ctx_d.fp_res = ctx_q.fp0;
                    ctx_d.st     = ST_IDLE;
                end else begin
                    ctx_d.sp    = sp_dec;
                    ctx_d.addr  = sp_dec;
                    ctx_d.wdata = fit(ctx_q.fp0, ctx_q.code);
                    ctx_d.we    = 1'b1;
                    ctx_d.st    = ST_PUSH_FP;
                end
            end
            ST_PUSH_FP: begin
                if (mem_ready) begin
                    ctx_d.tmp = ctx_q.sp;
                    if (ctx_q.lvl == '0) begin
                        ctx_d.st = ST_FINISH;
                    end else if (ctx_q.lvl == NEST_W'(1)) begin
                        ctx_d.sp    = sp_dec;
                        ctx_d.addr  = sp_dec;
                        ctx_d.wdata = fit(ctx_q.sp, ctx_q.code);
                        ctx_d.we    = 1'b1;
                        ctx_d.st    = ST_PUSH_TMP;
                    end else begin
                        ctx_d.cnt  = ctx_q.lvl - NEST_W'(1);
                        ctx_d.fp   = fp_dec;
                        ctx_d.addr = fp_dec;
                        ctx_d.we   = 1'b0;
                        ctx_d.st   = ST_RD_DISP;
                    end
                end
            end
            ST_RD_DISP: begin
                if (mem_ready) begin
                    ctx_d.sp    = sp_dec;
                    ctx_d.addr  = sp_dec;
                    ctx_d.wdata = fit(mem_rdata, ctx_q.code);
                    ctx_d.we    = 1'b1;
                    ctx_d.st    = ST_PUSH_DISP;
                end
            end
            ST_PUSH_DISP: begin
                if (mem_ready) begin
                    if (ctx_q.cnt == NEST_W'(1)) begin
                        ctx_d.sp    = sp_dec;
                        ctx_d.addr  = sp_dec;
                        ctx_d.wdata = fit(ctx_q.tmp, ctx_q.code);
                        ctx_d.we    = 1'b1;
                        ctx_d.st    = ST_PUSH_TMP;
                    end else begin
                        ctx_d.cnt  = ctx_q.cnt - NEST_W'(1);
                        ctx_d.fp   = fp_dec;
                        ctx_d.addr = fp_dec;
                        ctx_d.we   = 1'b0;
                        ctx_d.st   = ST_RD_DISP;
                    end
                end
            end
            ST_PUSH_TMP: begin
                if (mem_ready) begin
                    ctx_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                ctx_d.sp_res = sp_fin;
                ctx_d.fp_res = narrow
                    ? {ctx_q.fp0[PTR_W-1:NARROW_W], ctx_q.tmp[NARROW_W-1:0]}
                    : ctx_q.tmp;
                ctx_d.done   = 1'b1;
                ctx_d.st     = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        mem_req   = (ctx_q.st == ST_PUSH_FP)   || (ctx_q.st == ST_RD_DISP) ||
                    (ctx_q.st == ST_PUSH_DISP) || (ctx_q.st == ST_PUSH_TMP);
        mem_we    = ctx_q.we;
        mem_size  = ctx_q.code;
        mem_addr  = ctx_q.addr;
        mem_wdata = ctx_q.wdata;
        busy      = (ctx_q.st != ST_IDLE);
        done      = ctx_q.done;
        fault     = ctx_q.fault;
        sp_out    = ctx_q.sp_res;
        fp_out    = ctx_q.fp_res;
    end

    // R9: a pending access keeps its address, direction and data
    p_hold_access_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata));

    // R8: done and fault never pulse together
    p_end_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fault}));

    // R8: a fault is reported without any access just before it
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> !$past(mem_req));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: an idle block never requests memory
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R11: the first cycle after reset is idle
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !done && !fault);

endmodule

// File: tb/sim_frame_builder.sv
module sim_frame_builder;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   alloc_size = '0;
    logic [7:0]    nest_lvl = '0;
    logic [1:0]    opsize = '0;
    logic [W-1:0]  sp_in = '0, fp_in = '0, stack_floor = '0;
    logic          mem_req, mem_we, busy, done, fault;
    logic [1:0]    mem_size;
    logic [W-1:0]  mem_addr, mem_wdata, sp_out, fp_out;
    logic [W-1:0]  mem_rdata = '0;
    logic          mem_ready = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_builder u0 (
        .clk(clk), .rst(rst), .start(start), .alloc_size(alloc_size),
        .nest_lvl(nest_lvl), .opsize(opsize), .sp_in(sp_in), .fp_in(fp_in),
        .stack_floor(stack_floor), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
        .done(done), .fault(fault), .sp_out(sp_out), .fp_out(fp_out)
    );

    function automatic logic [W-1:0] step(input logic [W-1:0] b,
                                          input logic [W-1:0] a, input bit nar);
        logic [15:0] lo;
        lo = b[15:0] - a[15:0];
        return nar ? {b[W-1:16], lo} : b - a;
    endfunction

    function automatic logic [W-1:0] trunc(input logic [W-1:0] v, input logic [1:0] c);
        if (c == 2'b00) return {48'd0, v[15:0]};
        if (c == 2'b01) return {32'd0, v[31:0]};
        return v;
    endfunction

    function automatic logic [W-1:0] pat(input logic [W-1:0] a);
        return {a[31:0] ^ 32'h5A3C_96E1, ~a[31:0] + 32'h0101_0303};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // floor_mode: 0 floor zero, 1 floor at final SP, 2 floor one above final SP
    task automatic run_op(input logic [1:0] code, input logic [7:0] lvl,
                          input logic [15:0] alloc, input logic [W-1:0] sp,
                          input logic [W-1:0] fp, input int floor_mode,
                          input bit inject);
        logic [W-1:0] ea [64];
        logic [W-1:0] ed [64];
        bit           ew [64];
        int           ne = 0;
        int           lv = int'(lvl) % 32;
        bit           nar = (code == 2'b00);
        logic [W-1:0] ob = (code == 2'b00) ? 64'd2 : (code == 2'b01) ? 64'd4 : 64'd8;
        logic [W-1:0] s, f, tmp, fin, efp, esp, flo;
        bit           efault;
        int           got = 0, wait_c = 0, guard = 0;
        bit           holding = 0, stable_ok = 1, injected = 0, ended = 0;
        logic [W-1:0] ha, hd;
        logic         hw;
        string        tag;

        s = step(sp, ob, nar);
        ea[ne] = s; ed[ne] = trunc(fp, code); ew[ne] = 1; ne++;
        tmp = s; f = fp;
        if (lv >= 1) begin
            for (int k = 1; k < lv; k++) begin
                f = step(f, ob, nar);
                ea[ne] = f; ed[ne] = '0; ew[ne] = 0; ne++;
                s = step(s, ob, nar);
                ea[ne] = s; ed[ne] = trunc(pat(f), code); ew[ne] = 1; ne++;
            end
            s = step(s, ob, nar);
            ea[ne] = s; ed[ne] = trunc(tmp, code); ew[ne] = 1; ne++;
        end
        fin = step(s, {48'd0, alloc}, nar);
        efp = nar ? {fp[W-1:16], tmp[15:0]} : tmp;
        esp = fin;
        flo = (floor_mode == 0) ? '0 : (floor_mode == 1) ? fin : fin + 64'd1;
        efault = fin < flo;
        if (efault) begin
            ne = 0; esp = sp; efp = fp;
        end

        start = 1; opsize = code; nest_lvl = lvl; alloc_size = alloc;
        sp_in = sp; fp_in = fp; stack_floor = flo;
        @(negedge clk);
        start = 0;
        while (!ended) begin
            start = 0;
            if (done || fault) begin
                ended = 1;
            end else begin
                if (mem_ready) begin
                    mem_ready = 0;
                    holding = 0;
                end else if (mem_req) begin
                    if (!holding) begin
                        holding = 1; ha = mem_addr; hd = mem_wdata; hw = mem_we;
                    end else if (ha != mem_addr || hd != mem_wdata || hw != mem_we) begin
                        stable_ok = 0;
                    end
                    if (wait_c > 0) begin
                        wait_c--;
                    end else begin
                        if (got >= ne) begin
                            check(0, "R3 extra access", mem_addr, '0);
                        end else begin
                            tag = (got == 0) ? "R2" : (!ew[got]) ? "R4" :
                                  (got == ne - 1) ? "R5" : "R4";
                            if (nar) tag = {tag, "/R7"};
                            check(mem_addr == ea[got] && mem_we == ew[got] &&
                                  mem_size == code &&
                                  (!ew[got] || mem_wdata == ed[got]),
                                  tag, ew[got] ? mem_wdata : mem_addr,
                                  ew[got] ? ed[got] : ea[got]);
                        end
                        if (!mem_we) mem_rdata = pat(mem_addr);
                        mem_ready = 1;
                        got++;
                        wait_c = (got + lv) % 3;
                        if (inject && !injected) begin
                            // R10: start while busy with unrelated operands
                            injected = 1; start = 1; nest_lvl = 8'd7;
                            sp_in = 64'hDEAD_0000_0000_0000; fp_in = ~fp;
                            alloc_size = 16'h1234; opsize = ~code;
                        end
                    end
                end
                guard++;
                if (guard > 4000) begin
                    check(0, "R9 hang", W'(got), W'(ne));
                    ended = 1;
                end else begin
                    @(negedge clk);
                end
            end
        end
        mem_ready = 0;
        check(fault == efault && done == !efault, "R8 end kind",
              {62'd0, done, fault}, {62'd0, !efault, efault});
        check(sp_out == esp, inject ? "R6/R10 sp" : (efault ? "R8 sp" : "R6 sp"),
              sp_out, esp);
        check(fp_out == efp, nar ? "R7 fp" : (efault ? "R8 fp" : "R6 fp"),
              fp_out, efp);
        check(got == ne, (lvl >= 8'd32) ? "R1 access count" : "R3 access count",
              W'(got), W'(ne));
        check(stable_ok, "R9 hold", W'(stable_ok), 64'd1);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        check(0, "watchdog", W'(cyc), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] sps [2];
        logic [W-1:0] fps [2];
        int v = 0;
        sps[0] = 64'h0000_7FF0_0001_2000; fps[0] = 64'h0000_7FF0_0001_2400;
        sps[1] = 64'h1234_5678_9ABC_0010; fps[1] = 64'h1234_5678_9ABC_0006;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        check(!mem_req && !busy && !done && !fault, "R11 flags",
              {60'd0, mem_req, busy, done, fault}, '0);
        check(sp_out == '0 && fp_out == '0, "R11 outputs", sp_out | fp_out, '0);

        for (int c = 0; c < 4; c++) begin
            for (int li = 0; li < 36; li++) begin
                logic [7:0] lv8;
                lv8 = (li == 34) ? 8'd95 : (li == 35) ? 8'd255 : 8'(li);
                run_op(2'(c), lv8, (v % 2 == 0) ? 16'd0 : 16'hFFF0,
                       sps[v % 2], fps[v % 2], 0, (v % 5 == 0));
                v++;
            end
        end
        // R8: boundary of the stack floor
        for (int c = 0; c < 3; c++) begin
            for (int lv = 0; lv < 4; lv++) begin
                run_op(2'(c), 8'(lv), 16'h0100, sps[lv % 2], fps[lv % 2], 1, 0);
                run_op(2'(c), 8'(lv), 16'h0100, sps[lv % 2], fps[lv % 2], 2, 0);
            end
        end
        run_op(2'b10, 8'd3, 16'd64, sps[0], fps[0], 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule